// File: doc/BRIEF.md
# Video Line Timing Status Monitor

This block observes one or more received video streams and reports, per receive port, whether the line timing behaves. Each stream arrives as three single-bit strobes: a pixel-valid flag, a pulse marking the end of a line and a pulse marking the start of a frame. For every port the block measures how many valid pixels each line carries and how many lines each frame holds. It compares lines inside a frame with each other, and it compares each frame with the frame before it.

The results sit in a byte-wide status word per port. Four of its bits are sticky event flags that stay set until software reads them: unstable line length inside a frame, changed line length between frames, changed line count between frames, and packet-buffer overflow. Three further bits pass live status through from neighbouring logic that this block does not implement: a camera-serial receive error, a frequency-stable indication and a cable fault. A read strobe, qualified by a port-select value, returns the chosen port's byte one cycle later and clears that port's sticky flags. An event that lands in the same cycle as the read is kept for the next read.

Each port has its own independent monitor. The number of ports and the counter width are parameters.

Top module: `line_timing_status`

## Requirements
- R1: After reset every sticky flag of every port reads 0.
- R2: Status byte layout: bit 7 unstable line length, bit 6 line length changed, bit 5 always 0, bit 4 packet-buffer overflow, bit 3 receive error (live), bit 2 frequency stable (live), bit 1 cable fault (live), bit 0 line count changed.
- R3: A line's length is the number of cycles with pixel-valid high since the previous line-end or frame-start pulse. A pixel-valid in the line-end cycle counts toward that line. A line-end pulse in the same cycle as a frame-start pulse belongs to the frame that is ending.
- R4: A frame is the interval between two frame-start pulses, and lines seen before the first frame-start are ignored. If the lines of a frame do not all have the same length, bit 7 is set when that frame ends.
- R5: A frame's line length is the length of its first line. When a frame with at least one line ends, bit 6 is set if that length differs from the length of the previous completed frame that had lines. The first such frame after reset only records the value.
- R6: When a frame ends, bit 0 is set if its line count differs from the previous completed frame's count. The first completed frame after reset only records the count.
- R7: A cycle with the port's buffer-overflow input high sets bit 4 of that port.
- R8: A read strobe sampled on a rising edge places the selected port's byte on the read-data output, with read-valid high, after that edge. It clears that port's sticky bits. The live bits show the inputs at the strobe edge and are never cleared.
- R9: If a sticky flag is being set in the same cycle as a read of its port, the read returns the old value and the flag remains set for the next read.
- R10: Port-select value k reads and clears port k only. The ports' flags are independent of each other's stream activity.
- R11: Frame-end flags are visible to a read whose strobe is sampled on the third rising edge after the edge that sampled the frame-start pulse, or on any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | NUM_PORTS | Pixel-valid strobe per port |
| line_end | input | NUM_PORTS | End-of-line pulse per port |
| frame_start | input | NUM_PORTS | Start-of-frame pulse per port |
| buf_overflow | input | NUM_PORTS | Packet-buffer overflow event per port |
| rx_error | input | NUM_PORTS | Live receive-error status per port |
| freq_stable | input | NUM_PORTS | Live frequency-stable status per port |
| cable_fault | input | NUM_PORTS | Live cable-fault status per port |
| port_sel | input | SEL_W | Port chosen by a read |
| rd_stb | input | 1 | Read strobe |
| rd_data | output | 8 | Registered status byte of the selected port |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
A wrong internal state in this block reaches the ports only through a status read. A miscounted line or a stale reference makes no difference until the next frame-start, and about three cycles after that edge the flag it corrupts shows in the first read. A reference that was recorded wrongly on the first frame shows up as a false change flag one frame later. A sticky flag that drops early, or one that a read of the other port clears, shows as a missing bit on the next read of its own port. A lost set-versus-clear collision shows as a missing bit on the second of two reads issued back to back.

// File: rtl/lts_pkg.sv
package lts_pkg;

  localparam int BIT_UNSTABLE = 7;
  localparam int BIT_LEN_CHG  = 6;
  localparam int BIT_RSVD     = 5;
  localparam int BIT_BUF_OVF  = 4;
  localparam int BIT_RX_ERR   = 3;
  localparam int BIT_FREQ     = 2;
  localparam int BIT_CABLE    = 1;
  localparam int BIT_CNT_CHG  = 0;

  localparam int STICKY_W = 4;

  typedef struct packed {
    logic unstable;
    logic len_chg;
    logic buf_ovf;
    logic cnt_chg;
  } sticky_t;

  typedef struct packed {
    logic rx_err;
    logic freq_ok;
    logic cable_bad;
  } live_t;

  function automatic logic [7:0] pack_status(input sticky_t s, input live_t l);
    logic [7:0] b;
    b               = '0;
    b[BIT_UNSTABLE] = s.unstable;
    b[BIT_LEN_CHG]  = s.len_chg;
    b[BIT_RSVD]     = 1'b0;
    b[BIT_BUF_OVF]  = s.buf_ovf;
    b[BIT_RX_ERR]   = l.rx_err;
    b[BIT_FREQ]     = l.freq_ok;
    b[BIT_CABLE]    = l.cable_bad;
    b[BIT_CNT_CHG]  = s.cnt_chg;
    return b;
  endfunction

endpackage

// File: rtl/lts_line_meter.sv
module lts_line_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic             line_end,
  input  logic             frame_start,
  output logic             line_done,
  output logic [CNT_W-1:0] line_len,
  output logic             frame_done,
  output logic [CNT_W-1:0] frame_lines
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] pix_cnt;
  logic [CNT_W-1:0] row_cnt;
  logic             in_frame;
  logic [CNT_W-1:0] pix_next;
  logic [CNT_W-1:0] row_next;

  // saturating increment keeps long lines from wrapping to a small value
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic en);
    return (en && (v != '1)) ? v + ONE : v;
  endfunction

  always_comb begin
    pix_next = bump(pix_cnt, pix_valid);
    row_next = bump(row_cnt, line_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_cnt     <= '0;
      row_cnt     <= '0;
      in_frame    <= 1'b0;
      line_done   <= 1'b0;
      line_len    <= '0;
      frame_done  <= 1'b0;
      frame_lines <= '0;
    end else begin
      line_done  <= 1'b0;
      frame_done <= 1'b0;
      if (line_end) begin
        line_done <= in_frame;
        line_len  <= pix_next;
        pix_cnt   <= '0;
      end else begin
        pix_cnt <= pix_next;
      end
      if (frame_start) begin
        frame_done  <= in_frame;
        frame_lines <= row_next;
        row_cnt     <= '0;
        pix_cnt     <= '0;
        in_frame    <= 1'b1;
      end else begin
        row_cnt <= row_next;
      end
    end
  end

  assert_line_from_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && line_done) |-> $past(line_end));

  assert_frame_from_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && frame_done) |-> $past(frame_start));

  assert_no_line_before_frame_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_frame)) |-> (!line_done && !frame_done));

endmodule

// File: rtl/lts_frame_checker.sv
module lts_frame_checker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_done,
  input  logic [CNT_W-1:0] line_len,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] frame_lines,
  output logic             set_unstable,
  output logic             set_len_chg,
  output logic             set_cnt_chg
);

  logic             have_line;
  logic [CNT_W-1:0] ref_len;
  logic             mismatch;
  logic             have_prev_len;
  logic [CNT_W-1:0] prev_len;
  logic             have_prev_cnt;
  logic [CNT_W-1:0] prev_cnt;

  logic             line_mis;
  logic             frame_mis;
  logic             frame_has_line;
  logic [CNT_W-1:0] frame_ref;

  // a line closing in the frame-end cycle still belongs to the old frame
  always_comb begin
    line_mis       = line_done && have_line && (line_len != ref_len);
    frame_mis      = mismatch || line_mis;
    frame_has_line = have_line || line_done;
    frame_ref      = have_line ? ref_len : line_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_line     <= 1'b0;
      ref_len       <= '0;
      mismatch      <= 1'b0;
      have_prev_len <= 1'b0;
      prev_len      <= '0;
      have_prev_cnt <= 1'b0;
      prev_cnt      <= '0;
      set_unstable  <= 1'b0;
      set_len_chg   <= 1'b0;
      set_cnt_chg   <= 1'b0;
    end else begin
      set_unstable <= 1'b0;
      set_len_chg  <= 1'b0;
      set_cnt_chg  <= 1'b0;
      if (frame_done) begin
        set_unstable <= frame_mis;
        if (frame_has_line) begin
          set_len_chg   <= have_prev_len && (frame_ref != prev_len);
          prev_len      <= frame_ref;
          have_prev_len <= 1'b1;
        end
        set_cnt_chg   <= have_prev_cnt && (frame_lines != prev_cnt);
        prev_cnt      <= frame_lines;
        have_prev_cnt <= 1'b1;
        have_line     <= 1'b0;
        mismatch      <= 1'b0;
      end else if (line_done) begin
        if (!have_line) begin
          ref_len   <= line_len;
          have_line <= 1'b1;
        end else if (line_len != ref_len) begin
          mismatch <= 1'b1;
        end
      end
    end
  end

  assert_unstable_at_frame_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && set_unstable) |-> $past(frame_done));

  assert_len_chg_at_frame_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && set_len_chg) |-> ($past(frame_done) && $past(have_prev_len)));

  assert_cnt_chg_at_frame_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && set_cnt_chg) |-> ($past(frame_done) && $past(have_prev_cnt)));

  assert_first_frame_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(frame_done) && !$past(have_prev_cnt)) |-> !set_cnt_chg);

endmodule

// File: rtl/lts_sticky_flags.sv
module lts_sticky_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);

  // a set in the clearing cycle wins, so an event is never dropped
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~{W{clr}}) | set;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_set_survives_read_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(set[i])) |-> q[i]);

    assert_held_until_read_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(q[i]) && !$past(clr)) |-> q[i]);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(clr) && !$past(set[i])) |-> !q[i]);
  end

endmodule

// File: rtl/lts_port_monitor.sv
module lts_port_monitor
  import lts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pix_valid,
  input  logic    line_end,
  input  logic    frame_start,
  input  logic    buf_overflow,
  input  logic    clr,
  output sticky_t flags
);

  logic             line_done;
  logic [CNT_W-1:0] line_len;
  logic             frame_done;
  logic [CNT_W-1:0] frame_lines;
  logic             set_unstable;
  logic             set_len_chg;
  logic             set_cnt_chg;
  sticky_t          set_vec;
  logic [STICKY_W-1:0] q;

  lts_line_meter #(.CNT_W(CNT_W)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .pix_valid   (pix_valid),
    .line_end    (line_end),
    .frame_start (frame_start),
    .line_done   (line_done),
    .line_len    (line_len),
    .frame_done  (frame_done),
    .frame_lines (frame_lines)
  );

  lts_frame_checker #(.CNT_W(CNT_W)) u_check (
    .clk          (clk),
    .rst          (rst),
    .line_done    (line_done),
    .line_len     (line_len),
    .frame_done   (frame_done),
    .frame_lines  (frame_lines),
    .set_unstable (set_unstable),
    .set_len_chg  (set_len_chg),
    .set_cnt_chg  (set_cnt_chg)
  );

  always_comb begin
    set_vec.unstable = set_unstable;
    set_vec.len_chg  = set_len_chg;
    set_vec.buf_ovf  = buf_overflow;
    set_vec.cnt_chg  = set_cnt_chg;
  end

  lts_sticky_flags #(.W(STICKY_W)) u_flags (
    .clk (clk),
    .rst (rst),
    .set (set_vec),
    .clr (clr),
    .q   (q)
  );

  assign flags = sticky_t'(q);

  assert_overflow_captured_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(buf_overflow)) |-> flags.buf_ovf);

endmodule

// File: rtl/line_timing_status.sv
module line_timing_status
  import lts_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int CNT_W     = 16,
  parameter int SEL_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] pix_valid,
  input  logic [NUM_PORTS-1:0] line_end,
  input  logic [NUM_PORTS-1:0] frame_start,
  input  logic [NUM_PORTS-1:0] buf_overflow,
  input  logic [NUM_PORTS-1:0] rx_error,
  input  logic [NUM_PORTS-1:0] freq_stable,
  input  logic [NUM_PORTS-1:0] cable_fault,
  input  logic [SEL_W-1:0]     port_sel,
  input  logic                 rd_stb,
  output logic [7:0]           rd_data,
  output logic                 rd_valid
);

  sticky_t              flags [NUM_PORTS];
  logic [NUM_PORTS-1:0] clr_vec;
  sticky_t              sel_flags;
  live_t                sel_live;
  logic                 sel_hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign clr_vec[p] = rd_stb && (port_sel == SEL_W'(p));

    lts_port_monitor #(.CNT_W(CNT_W)) u_mon (
      .clk          (clk),
      .rst          (rst),
      .pix_valid    (pix_valid[p]),
      .line_end     (line_end[p]),
      .frame_start  (frame_start[p]),
      .buf_overflow (buf_overflow[p]),
      .clr          (clr_vec[p]),
      .flags        (flags[p])
    );

    assert_clear_only_selected_R10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(flags[p].cnt_chg) && !$past(rd_stb && (port_sel == SEL_W'(p))))
        |-> flags[p].cnt_chg);
  end

  always_comb begin
    sel_flags = '0;
    sel_live  = '0;
    sel_hit   = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_sel == SEL_W'(p)) begin
        sel_flags          = flags[p];
        sel_live.rx_err    = rx_error[p];
        sel_live.freq_ok   = freq_stable[p];
        sel_live.cable_bad = cable_fault[p];
        sel_hit            = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= sel_hit ? pack_status(sel_flags, sel_live) : '0;
    end
  end

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_stb)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[BIT_RSVD] == 1'b0));

endmodule

// File: tb/line_timing_status_test.sv
module line_timing_status_test;

  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pix, le, fs, ovf, rxe, frq, cab;
  logic          sel;
  logic          rd;
  logic [7:0]    rdata;
  logic          rvalid;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference model state, one slot per port
  bit in_frame [NP];
  bit have_line[NP];
  bit mism     [NP];
  bit hp_len   [NP];
  bit hp_cnt   [NP];
  int ref_len  [NP];
  int prev_len [NP];
  int prev_cnt [NP];
  int cur_lines[NP];
  bit e_unst   [NP];
  bit e_lchg   [NP];
  bit e_cchg   [NP];
  bit e_buf    [NP];

  always #4 clk = ~clk;

  line_timing_status #(.NUM_PORTS(NP), .CNT_W(16)) uut (
    .clk          (clk),
    .rst          (rst),
    .pix_valid    (pix),
    .line_end     (le),
    .frame_start  (fs),
    .buf_overflow (ovf),
    .rx_error     (rxe),
    .freq_stable  (frq),
    .cable_fault  (cab),
    .port_sel     (sel),
    .rd_stb       (rd),
    .rd_data      (rdata),
    .rd_valid     (rvalid)
  );

  // R2 layout: 7 unstable, 6 len chg, 5 zero, 4 overflow, 3..1 live, 0 count chg
  function automatic logic [7:0] exp_byte(int p);
    return {e_unst[p], e_lchg[p], 1'b0, e_buf[p], rxe[p], frq[p], cab[p], e_cchg[p]};
  endfunction

  function automatic void model_line(int p, int len);
    if (!in_frame[p]) return;
    if (!have_line[p]) begin
      ref_len[p]   = len;
      have_line[p] = 1'b1;
    end else if (len != ref_len[p]) begin
      mism[p] = 1'b1;
    end
    cur_lines[p]++;
  endfunction

  function automatic void model_frame(int p);
    if (in_frame[p]) begin
      if (mism[p]) e_unst[p] = 1'b1;
      if (have_line[p]) begin
        if (hp_len[p] && ref_len[p] != prev_len[p]) e_lchg[p] = 1'b1;
        prev_len[p] = ref_len[p];
        hp_len[p]   = 1'b1;
      end
      if (hp_cnt[p] && cur_lines[p] != prev_cnt[p]) e_cchg[p] = 1'b1;
      prev_cnt[p] = cur_lines[p];
      hp_cnt[p]   = 1'b1;
    end
    in_frame[p]  = 1'b1;
    have_line[p] = 1'b0;
    mism[p]      = 1'b0;
    cur_lines[p] = 0;
  endfunction

  function automatic void model_clear(int p);
    e_unst[p] = 1'b0;
    e_lchg[p] = 1'b0;
    e_cchg[p] = 1'b0;
    e_buf[p]  = 1'b0;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // R8: strobe set at a falling edge, byte sampled one cycle later
  task automatic read_port(int p, string req);
    logic [7:0] e;
    @(negedge clk);
    sel = p[0];
    rd  = 1'b1;
    rxe = NP'($urandom);
    frq = NP'($urandom);
    cab = NP'($urandom);
    e   = exp_byte(p);
    model_clear(p);
    @(negedge clk);
    rd = 1'b0;
    check(req, rdata, e);
    check({req, " valid"}, {7'b0, rvalid}, 8'h01);
  endtask

  task automatic drive_fs(int p);
    @(negedge clk);
    fs[p] = 1'b1;
    @(negedge clk);
    fs[p] = 1'b0;
  endtask

  task automatic start_frame(int p);
    model_frame(p);
    drive_fs(p);
  endtask

  // R3: last pixel shares the line-end cycle; optional frame-start in that cycle
  task automatic send_line(int p, int len, bit gaps, bit with_fs);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk);
        pix[p] = 1'b0;
        le[p]  = 1'b0;
      end
      @(negedge clk);
      pix[p] = 1'b1;
      le[p]  = (i == len - 1);
      fs[p]  = with_fs && (i == len - 1);
    end
    @(negedge clk);
    pix[p] = 1'b0;
    le[p]  = 1'b0;
    fs[p]  = 1'b0;
    model_line(p, len);
    if (with_fs) model_frame(p);
  endtask

  task automatic lines(int p, int n, int len);
    for (int i = 0; i < n; i++) send_line(p, len, 1'b1, 1'b0);
  endtask

  task automatic pulse_ovf(int p);
    @(negedge clk);
    ovf[p] = 1'b1;
    @(negedge clk);
    ovf[p] = 1'b0;
    e_buf[p] = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    void'($urandom(32'd2024));
    rst = 1'b1;
    pix = '0; le = '0; fs = '0; ovf = '0; rxe = '0; frq = '0; cab = '0;
    sel = 1'b0;
    rd  = 1'b0;
    for (int p = 0; p < NP; p++) begin
      in_frame[p] = 0; have_line[p] = 0; mism[p] = 0; hp_len[p] = 0; hp_cnt[p] = 0;
      ref_len[p] = 0; prev_len[p] = 0; prev_cnt[p] = 0; cur_lines[p] = 0;
      model_clear(p);
    end
    idle(5);
    rst = 1'b0;

    // R1 reset state, R2 live pass-through
    read_port(0, "R1");
    read_port(1, "R1 R2");

    // lines before the first frame-start are ignored (R4)
    lines(0, 2, 9);
    start_frame(0);
    lines(0, 4, 5);
    start_frame(0);
    idle(4);
    read_port(0, "R5 R6 first frame quiet");
    lines(0, 4, 5);
    start_frame(0);
    idle(4);
    read_port(0, "R6 unchanged frame");
    lines(0, 4, 7);
    start_frame(0);
    idle(4);
    read_port(0, "R5 length change");
    lines(0, 5, 7);
    start_frame(0);
    idle(4);
    read_port(0, "R6 count change");
    send_line(0, 7, 1'b1, 1'b0);
    send_line(0, 7, 1'b1, 1'b0);
    send_line(0, 3, 1'b1, 1'b0);
    send_line(0, 7, 1'b1, 1'b0);
    start_frame(0);
    idle(4);
    read_port(0, "R4 unstable");
    read_port(0, "R8 cleared by read");

    // R3: line-end coinciding with frame-start ends the old frame
    lines(0, 3, 7);
    send_line(0, 7, 1'b1, 1'b1);
    idle(4);
    read_port(0, "R3 coincident line");
    lines(0, 4, 7);
    start_frame(0);
    idle(4);
    read_port(0, "R3 count kept");

    // R11: strobe on the third edge after frame-start
    lines(0, 3, 7);
    start_frame(0);
    idle(1);
    read_port(0, "R11 latency");

    // R9: frame event collides with a read
    lines(0, 2, 7);
    drive_fs(0);
    read_port(0, "R9 frame collision old value");
    model_frame(0);
    idle(4);
    read_port(0, "R9 frame collision kept");

    // R7 overflow
    pulse_ovf(0);
    read_port(0, "R7 overflow set");
    read_port(0, "R7 overflow cleared");

    // R9 overflow collides with a read
    @(negedge clk);
    sel = 1'b0;
    rd  = 1'b1;
    ovf[0] = 1'b1;
    e = exp_byte(0);
    model_clear(0);
    e_buf[0] = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    ovf[0] = 1'b0;
    check("R9 overflow collision old value", rdata, e);
    read_port(0, "R9 overflow collision kept");

    // R10 independence
    read_port(1, "R10 idle port untouched");
    pulse_ovf(0);
    start_frame(1);
    lines(1, 2, 4);
    start_frame(1);
    lines(1, 3, 4);
    start_frame(1);
    idle(4);
    read_port(1, "R10 port one count change");
    read_port(0, "R10 port zero kept");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int p;
      int nl;
      int base;
      p = int'($urandom % 2);
      start_frame(p);
      idle(4);
      if ($urandom % 2 == 0) read_port(p, "R4 R5 R6 random");
      if ($urandom % 8 == 0) pulse_ovf(p);
      nl   = 1 + int'($urandom % 4);
      base = 2 + int'($urandom % 3);
      for (int k = 0; k < nl; k++)
        send_line(p, ($urandom % 5 == 0) ? base + 1 : base, 1'b1, 1'b0);
    end
    start_frame(0);
    start_frame(1);
    idle(4);
    read_port(0, "R4 R5 R6 random final");
    read_port(1, "R4 R5 R6 random final");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule